// File: doc/BRIEF.md
# Event Counter with Glitch-Free Clock-Source Select

This block is a 16-bit up-counter that a simple register bus can read and load. Each count step is gated by one of eight sources, picked by a 3-bit select field. Six of these sources are single-cycle tick strobes from an external prescaler. The other two are the rising or the falling edge of an asynchronous input pin. The pin is first brought into the system clock domain by a flop chain, and its edges are then found by a history register. When the counter is loaded with the two's complement of N, the overflow flag rises after N events.

A control word holds the select field, two drive enables for a pair of time base buses, a 3-bit interrupt level, a read-only copy of the synchronized pin level, and a sticky overflow flag. An interrupt request is raised while the flag is set and the level field is nonzero. Two small state machines do the work. The source FSM has states `SRC_RUN` and `SRC_SETTLE`. Any write that changes the select moves it from `SRC_RUN` to `SRC_SETTLE`, and it returns to `SRC_RUN` one cycle later unless the select changes again. The flag FSM has states `OVF_CLEAR`, `OVF_PENDING` and `OVF_ARMED`. A wrap moves it from `OVF_CLEAR` (or `OVF_ARMED`) to `OVF_PENDING`. A control read moves it from `OVF_PENDING` to `OVF_ARMED`. A control write with the flag bit at 0 moves it from `OVF_ARMED` to `OVF_CLEAR`.

Top module: `evt_timer`

## Requirements
- R1: After reset the count reads 0x0000, the control word reads 0x0000, and `irq_req`, `tb_a_drv` and `tb_b_drv` are low.
- R2: A bus write with `bus_addr`=0 loads the count. A read with `bus_addr`=0 returns the count one cycle later, with `bus_rvalid` high.
- R3: Control word bits [2:0] select the source. Codes 0 to 5 pick `presc_tick[code]`, and the count rises by one at each clock edge where that tick is high. The unselected ticks have no effect.
- R4: A step from 0xFFFF wraps the count to 0x0000 and sets the overflow flag (control bit 15). `irq_req` is high while the flag is set and the level field (control bits [7:5]) is nonzero. `irq_lvl` carries that level. With level 0, `irq_req` stays low.
- R5: Loading 0x0000 while the count is 0xFFFF and a step is due leaves the flag clear and raises no request.
- R6: A count load in the same cycle as a step wins, so the count becomes exactly the written value.
- R7: Code 6 counts rising edges of `ext_pin`, and code 7 counts falling edges. Control bit 14 reads the synchronized pin level.
- R8: A select change never advances the count by itself. The edge history is reloaded with the current level, and no step is taken in the cycle after the change.
- R9: The flag clears only when a control read that sees it set is followed by a control write with bit 15 at 0. A write of 0 without that read, or a write of 1, leaves the flag unchanged.
- R10: Control bits 3 and 4 drive `tb_a_drv` and `tb_b_drv`, and `tb_count` carries the count. A control write with both bits set leaves both enables unchanged.
- R11: A pin toggling every two system clocks (a quarter of the clock rate) is counted on every selected edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 1 | 0 selects the count, 1 selects the control word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| presc_tick | input | 6 | Prescaler tick strobes |
| ext_pin | input | 1 | Asynchronous external event pin |
| irq_req | output | 1 | Interrupt request |
| irq_lvl | output | 3 | Requested interrupt level |
| tb_a_drv | output | 1 | Drive enable for time base bus A |
| tb_b_drv | output | 1 | Drive enable for time base bus B |
| tb_count | output | 16 | Count value for the time base bus |

## Verification
A tick that is high in a cycle moves the count at the next edge. A pin change needs two synchronizer edges before it is seen, and the count moves at the third edge. A select or flag write takes effect at the edge where it is sampled, read data arrives one edge after the strobe, and `irq_req` follows the flag with no delay.

The driver pushes each expected read value into a queue when it raises the strobe, and the monitor pops it when `bus_rvalid` is seen on a falling edge. Stimulus is always followed by at least one idle falling edge (four after a pin change), so every result has settled before it is sampled. Direct port checks are also made on falling edges, after the last edge that could move them.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    typedef enum logic {
        SRC_RUN    = 1'b0,
        SRC_SETTLE = 1'b1
    } src_state_t;

    typedef enum logic [1:0] {
        OVF_CLEAR   = 2'd0,
        OVF_PENDING = 2'd1,
        OVF_ARMED   = 2'd2
    } ovf_state_t;

endpackage

// File: rtl/evt_pin_sync.sv
module evt_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic hist_load,
    input  logic hist_track,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
        end
    end

    assign level = sync_q[STAGES-1];

    // History follows the level only while a pin source is in use,
    // and is reloaded whenever the select changes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else if (hist_load || hist_track) begin
            prev_q <= level;
        end
    end

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;

    // R8: after a reload, an edge shows only if the level really moved
    a_r8_reload_no_false_edge: assert property (@(posedge clk) disable iff (!rst_n)
        hist_load |=> ((rise || fall) == (level != $past(level))));

endmodule

// File: rtl/evt_src_sel.sv
module evt_src_sel
    import evt_timer_pkg::*;
#(
    parameter int N_PRESC = 6,
    parameter int SEL_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_wr,
    input  logic [SEL_W-1:0]   sel,
    input  logic [N_PRESC-1:0] presc_tick,
    input  logic               pin_rise,
    input  logic               pin_fall,
    output logic               cnt_en,
    output logic               hist_load,
    output logic               hist_track
);
    localparam int NSRC = 2 ** SEL_W;
    localparam logic [SEL_W-1:0] RISE_CODE = SEL_W'(N_PRESC);
    localparam logic [SEL_W-1:0] FALL_CODE = SEL_W'(N_PRESC + 1);

    src_state_t state_q, state_d;
    logic [NSRC-1:0] src_vec;
    logic            src_hit;
    logic            ext_mode;

    genvar gi;
    generate
        for (gi = 0; gi < N_PRESC; gi++) begin : g_tick
            assign src_vec[gi] = presc_tick[gi];
        end
        assign src_vec[N_PRESC]     = pin_rise;
        assign src_vec[N_PRESC + 1] = pin_fall;
        for (gi = N_PRESC + 2; gi < NSRC; gi++) begin : g_pad
            assign src_vec[gi] = 1'b0;
        end
    endgenerate

    assign src_hit  = src_vec[sel];
    assign ext_mode = (sel == RISE_CODE) || (sel == FALL_CODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SRC_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        cnt_en     = 1'b0;
        hist_load  = sel_wr;
        hist_track = ext_mode;
        unique case (state_q)
            SRC_RUN: begin
                cnt_en = src_hit;
                if (sel_wr) state_d = SRC_SETTLE;
            end
            SRC_SETTLE: begin
                hist_track = 1'b1;
                if (!sel_wr) state_d = SRC_RUN;
            end
            default: state_d = SRC_RUN;
        endcase
    end

endmodule

// File: rtl/evt_count_core.sv
module evt_count_core
    import evt_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             flag_rd,
    input  logic             flag_clr_wr,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag
);
    logic [CNT_W-1:0] count_q;
    logic             wrap;
    ovf_state_t       ovf_q, ovf_d;

    assign wrap = cnt_en && !cnt_wr && (&count_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (cnt_wr) begin
            count_q <= wdata;
        end else if (cnt_en) begin
            count_q <= count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= OVF_CLEAR;
        end else begin
            ovf_q <= ovf_d;
        end
    end

    always_comb begin
        ovf_d = ovf_q;
        unique case (ovf_q)
            OVF_CLEAR:   if (wrap) ovf_d = OVF_PENDING;
            OVF_PENDING: if (flag_rd) ovf_d = OVF_ARMED;
            OVF_ARMED: begin
                if (wrap)             ovf_d = OVF_PENDING;
                else if (flag_clr_wr) ovf_d = OVF_CLEAR;
            end
            default: ovf_d = OVF_CLEAR;
        endcase
    end

    assign count    = count_q;
    assign ovf_flag = (ovf_q != OVF_CLEAR);

    // R4: a step from all ones wraps to zero and raises the flag
    a_r4_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !cnt_wr && (&count_q)) |=> (ovf_flag && count_q == '0));

    // R6: a load wins over a step in the same cycle
    a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count_q == $past(wdata)));

    // R9: the flag only falls on a clearing write
    a_r9_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_flag) |-> $past(flag_clr_wr));

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int N_PRESC     = 6,
    parameter int LVL_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic               bus_addr,
    input  logic [CNT_W-1:0]   bus_wdata,
    output logic [CNT_W-1:0]   bus_rdata,
    output logic               bus_rvalid,
    input  logic [N_PRESC-1:0] presc_tick,
    input  logic               ext_pin,
    output logic               irq_req,
    output logic [LVL_W-1:0]   irq_lvl,
    output logic               tb_a_drv,
    output logic               tb_b_drv,
    output logic [CNT_W-1:0]   tb_count
);
    localparam int SEL_W    = $clog2(N_PRESC + 2);
    localparam int SEL_LSB  = 0;
    localparam int DRVA_BIT = SEL_LSB + SEL_W;
    localparam int DRVB_BIT = DRVA_BIT + 1;
    localparam int LVL_LSB  = DRVB_BIT + 1;
    localparam int PIN_BIT  = CNT_W - 2;
    localparam int OVF_BIT  = CNT_W - 1;

    logic [SEL_W-1:0] sel_q;
    logic [LVL_W-1:0] lvl_q;
    logic             drv_a_q, drv_b_q;
    logic             ctrl_wr, cnt_wr, sel_wr, sel_wr_d;
    logic [SEL_W-1:0] new_sel;
    logic             pin_level, pin_rise, pin_fall;
    logic             hist_load, hist_track, cnt_en;
    logic [CNT_W-1:0] count;
    logic             ovf_flag;
    logic [CNT_W-1:0] ctrl_word;

    assign ctrl_wr = bus_wr && bus_addr;
    assign cnt_wr  = bus_wr && !bus_addr;
    assign new_sel = bus_wdata[SEL_LSB +: SEL_W];
    assign sel_wr  = ctrl_wr && (new_sel != sel_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= '0;
            lvl_q    <= '0;
            drv_a_q  <= 1'b0;
            drv_b_q  <= 1'b0;
            sel_wr_d <= 1'b0;
        end else begin
            sel_wr_d <= sel_wr;
            if (ctrl_wr) begin
                sel_q <= new_sel;
                lvl_q <= bus_wdata[LVL_LSB +: LVL_W];
                if (!(bus_wdata[DRVA_BIT] && bus_wdata[DRVB_BIT])) begin
                    drv_a_q <= bus_wdata[DRVA_BIT];
                    drv_b_q <= bus_wdata[DRVB_BIT];
                end
            end
        end
    end

    evt_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin        (ext_pin),
        .hist_load  (hist_load),
        .hist_track (hist_track),
        .level      (pin_level),
        .rise       (pin_rise),
        .fall       (pin_fall)
    );

    evt_src_sel #(.N_PRESC(N_PRESC), .SEL_W(SEL_W)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_wr     (sel_wr),
        .sel        (sel_q),
        .presc_tick (presc_tick),
        .pin_rise   (pin_rise),
        .pin_fall   (pin_fall),
        .cnt_en     (cnt_en),
        .hist_load  (hist_load),
        .hist_track (hist_track)
    );

    evt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_en      (cnt_en),
        .cnt_wr      (cnt_wr),
        .wdata       (bus_wdata),
        .flag_rd     (bus_rd && bus_addr),
        .flag_clr_wr (ctrl_wr && !bus_wdata[OVF_BIT]),
        .count       (count),
        .ovf_flag    (ovf_flag)
    );

    always_comb begin
        ctrl_word                      = '0;
        ctrl_word[SEL_LSB +: SEL_W]    = sel_q;
        ctrl_word[DRVA_BIT]            = drv_a_q;
        ctrl_word[DRVB_BIT]            = drv_b_q;
        ctrl_word[LVL_LSB +: LVL_W]    = lvl_q;
        ctrl_word[PIN_BIT]             = pin_level;
        ctrl_word[OVF_BIT]             = ovf_flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) bus_rdata <= bus_addr ? ctrl_word : count;
        end
    end

    assign irq_req  = ovf_flag && (lvl_q != '0);
    assign irq_lvl  = lvl_q;
    assign tb_a_drv = drv_a_q;
    assign tb_b_drv = drv_b_q;
    assign tb_count = count;

    // R10: the two bus drivers are never on together
    a_r10_drv_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tb_a_drv && tb_b_drv));

    // R5: loading zero at all ones never raises a clear flag
    a_r5_zero_load_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && bus_wdata == '0 && (&count) && !ovf_flag) |=> !ovf_flag);

    // R8: no step in the cycle after a select change
    a_r8_switch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr_d && !cnt_wr) |=> (count == $past(count)));

endmodule

// File: tb/evt_timer_bench.sv
module evt_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd, bus_addr;
    logic [15:0] bus_wdata, bus_rdata, tb_count;
    logic        bus_rvalid;
    logic [5:0]  presc_tick;
    logic        ext_pin;
    logic        irq_req, tb_a_drv, tb_b_drv;
    logic [2:0]  irq_lvl;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    evt_timer u_evt_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .presc_tick(presc_tick), .ext_pin(ext_pin),
        .irq_req(irq_req), .irq_lvl(irq_lvl), .tb_a_drv(tb_a_drv),
        .tb_b_drv(tb_b_drv), .tb_count(tb_count)
    );

    function automatic logic [15:0] cw(input logic [2:0] sel, input logic da,
                                       input logic db, input logic [2:0] lvl,
                                       input logic ovf, input logic pin);
        return {ovf, pin, 6'b0, lvl, db, da, sel};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read values as results appear
    always @(negedge clk) begin
        if (!done && rst_n === 1'b1 && bus_rvalid === 1'b1) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL unexpected read actual=%h expected=none", bus_rdata);
            end else begin
                chk(tag_q.pop_front(), 32'(bus_rdata), 32'(exp_q.pop_front()));
            end
        end
    end

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic a, input logic [15:0] e, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int idx, input int n);
        @(negedge clk);
        presc_tick[idx] = 1'b1;
        repeat (n) @(negedge clk);
        presc_tick[idx] = 1'b0;
    endtask

    task automatic pin_pulse(input int hi, input int lo);
        @(negedge clk);
        ext_pin = 1'b1;
        repeat (hi) @(negedge clk);
        ext_pin = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic wr_with_tick(input logic [15:0] d);
        @(negedge clk);
        presc_tick[2] = 1'b1;
        bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = d;
        @(negedge clk);
        presc_tick[2] = 1'b0;
        bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
        presc_tick = '0; ext_pin = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq_req", 32'(irq_req), 0);
        chk("R1 drive enables", 32'({tb_a_drv, tb_b_drv}), 0);
        rd(0, 16'h0000, "R1 count");
        rd(1, 16'h0000, "R1 ctrl");

        // R2 load and read back
        wr(0, 16'h1234);
        rd(0, 16'h1234, "R2 count 1234");
        wr(0, 16'hA5A5);
        rd(0, 16'hA5A5, "R2 count A5A5");

        // R3 selected tick counts, others ignored
        wr(1, cw(3'd2, 0, 0, 3'd0, 0, 0));
        wr(0, 16'd10);
        ticks(2, 5);
        rd(0, 16'd15, "R3 selected tick");
        ticks(0, 4);
        ticks(5, 4);
        rd(0, 16'd15, "R3 unselected ticks");

        // R4 wrap with nonzero level
        wr(1, cw(3'd2, 0, 0, 3'd3, 0, 0));
        wr(0, 16'hFFFE);
        ticks(2, 2);
        rd(0, 16'h0000, "R4 wrap to zero");
        chk("R4 irq_req level 3", 32'(irq_req), 1);
        chk("R4 irq_lvl", 32'(irq_lvl), 3);
        rd(1, cw(3'd2, 0, 0, 3'd3, 1, 0), "R4 flag set");
        wr(1, cw(3'd2, 0, 0, 3'd3, 0, 0));
        chk("R9 irq after clear", 32'(irq_req), 0);
        rd(1, cw(3'd2, 0, 0, 3'd3, 0, 0), "R9 cleared after read");

        // R4 level zero: flag but no request
        wr(1, cw(3'd2, 0, 0, 3'd0, 0, 0));
        wr(0, 16'hFFFF);
        ticks(2, 1);
        chk("R4 irq_req level 0", 32'(irq_req), 0);

        // R9 clear needs a prior read
        wr(1, cw(3'd2, 0, 0, 3'd0, 0, 0));
        rd(1, cw(3'd2, 0, 0, 3'd0, 1, 0), "R9 no clear without read");
        wr(1, cw(3'd2, 0, 0, 3'd0, 0, 0));
        rd(1, cw(3'd2, 0, 0, 3'd0, 0, 0), "R9 cleared");
        wr(1, cw(3'd2, 0, 0, 3'd0, 1, 0));
        rd(1, cw(3'd2, 0, 0, 3'd0, 0, 0), "R9 write one no set");

        // R5 zero load at all ones while stepping
        wr(1, cw(3'd2, 0, 0, 3'd3, 0, 0));
        wr(0, 16'hFFFF);
        wr_with_tick(16'h0000);
        chk("R5 irq_req", 32'(irq_req), 0);
        rd(1, cw(3'd2, 0, 0, 3'd3, 0, 0), "R5 flag clear");
        rd(0, 16'h0000, "R5 count");

        // R6 load wins over step
        wr_with_tick(16'h0100);
        rd(0, 16'h0100, "R6 load wins");

        // R7 rising edges and pin level bit
        wr(0, 16'h0000);
        wr(1, cw(3'd6, 0, 0, 3'd0, 0, 0));
        @(negedge clk);
        ext_pin = 1'b1;
        repeat (4) @(negedge clk);
        rd(1, cw(3'd6, 0, 0, 3'd0, 0, 1), "R7 pin level");
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 3; i++) pin_pulse(4, 4);
        rd(0, 16'd4, "R7 rising count");

        // R7 falling edges
        wr(1, cw(3'd7, 0, 0, 3'd0, 0, 0));
        for (int i = 0; i < 2; i++) pin_pulse(4, 4);
        rd(0, 16'd6, "R7 falling count");

        // R11 pin at a quarter of the clock rate
        wr(1, cw(3'd6, 0, 0, 3'd0, 0, 0));
        for (int i = 0; i < 8; i++) pin_pulse(2, 2);
        repeat (4) @(negedge clk);
        rd(0, 16'd14, "R11 quarter rate");

        // R8 select change makes no false edge
        wr(0, 16'h0040);
        wr(1, cw(3'd0, 0, 0, 3'd0, 0, 0));
        ext_pin = 1'b1;
        repeat (5) @(negedge clk);
        wr(1, cw(3'd6, 0, 0, 3'd0, 0, 0));
        repeat (5) @(negedge clk);
        rd(0, 16'h0040, "R8 switch to rising");
        wr(1, cw(3'd0, 0, 0, 3'd0, 0, 0));
        ext_pin = 1'b0;
        repeat (5) @(negedge clk);
        wr(1, cw(3'd7, 0, 0, 3'd0, 0, 0));
        repeat (5) @(negedge clk);
        rd(0, 16'h0040, "R8 switch to falling");

        // R10 time base drive
        wr(1, cw(3'd0, 1, 0, 3'd0, 0, 0));
        chk("R10 drive A", 32'({tb_a_drv, tb_b_drv}), 32'b10);
        chk("R10 tb_count", 32'(tb_count), 32'h0040);
        wr(1, cw(3'd0, 1, 1, 3'd0, 0, 0));
        chk("R10 both rejected", 32'({tb_a_drv, tb_b_drv}), 32'b10);
        rd(1, cw(3'd0, 1, 0, 3'd0, 0, 0), "R10 ctrl after both");
        wr(1, cw(3'd0, 0, 1, 3'd0, 0, 0));
        chk("R10 drive B", 32'({tb_a_drv, tb_b_drv}), 32'b01);

        repeat (5) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL scoreboard actual=%0d pending expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule